// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is the retirement queue of a speculative out-of-order core. Each instruction takes a slot when it issues, and the slot number becomes the tag that names its result. Results come back out of order on a writeback bus and are stored in their slot. Newly issuing instructions can ask for the youngest in-flight producer of an architectural register and get its value once that value exists. Slots retire strictly in program order from the oldest end. A retiring register write or store is driven out to the register file or the store path.

When the oldest slot holds a branch resolved as mispredicted, or an instruction that raised an exception, it does not retire. Instead the whole buffer is emptied and a redirect address is driven for one cycle. For a branch the address is the correct target; for an exception it is a fixed handler address. Nothing at or after the faulting slot ever reaches architectural state.

The control is a two-state machine:

| State | Meaning |
|---|---|
| RUN | Normal allocation, writeback and retirement. |
| FLUSH | The buffer has just been emptied. The redirect is driven and allocation is refused. |

It has two transitions:

| Transition | Condition |
|---|---|
| FAULT_SEEN, RUN to FLUSH | The oldest slot is valid, complete and flagged. |
| RESUME, FLUSH to RUN | Always, after one cycle. |

Top module: `rob_inorder`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready`=1, `full`=0, `alloc_tag`=0, and no commit, flush or lookup hit is signalled.
- R2: An allocation is taken when `alloc_valid` and `alloc_ready` are both high. The tag granted equals `alloc_tag`, which starts at 0 and advances by one modulo the depth (8) with each allocation. `alloc_kind` encodes 0 = register write, 1 = store, 2 = branch.
- R3: `full` is high exactly when 8 slots are occupied. While full, `alloc_ready` is low and a request is ignored: it creates no entry.
- R4: A writeback to an occupied slot stores `wb_value` and marks the slot complete. From the next cycle a lookup of that slot reports it ready with that value.
- R5: A lookup of register `lk_reg` hits on the youngest occupied register-write slot whose destination low 5 bits equal `lk_reg`, and returns that slot's tag. Store and branch slots never hit.
- R6: If the slot found by a lookup is being written back in the same cycle, the lookup reports it ready with the incoming `wb_value`.
- R7: Only the oldest slot retires, and only once complete. Younger complete slots wait. Retirement takes one cycle per slot, starting the cycle after the oldest slot completes.
- R8: A retiring register-write slot pulses `cm_reg_we` with `cm_reg_idx` = destination low 5 bits and `cm_value`. A retiring store pulses `cm_store_we` with `cm_store_addr` = destination. A correctly predicted branch retires with neither.
- R9: A complete mispredicted branch at the oldest slot does not retire. One cycle later `flush_out` is high for exactly one cycle, with `redirect_pc` = low 16 bits of the branch's `wb_value` and `fault_pc` = the branch's PC. Afterwards the buffer is empty.
- R10: A complete slot with its exception flag at the oldest position flushes the same way, with `redirect_pc` = `HANDLER_PC`. Neither that slot nor any younger one ever pulses a commit.
- R11: While the oldest slot is complete and faulting, and during the `flush_out` cycle, `alloc_ready` is low and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_kind | input | 2 | 0 register write, 1 store, 2 branch |
| alloc_dest | input | DEST_W | Register number (low bits) or store address |
| alloc_pc | input | PC_W | Program counter of the issuing instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | IDX_W | Tag the next allocation receives |
| full | output | 1 | All slots occupied |
| wb_valid | input | 1 | Result broadcast present |
| wb_tag | input | IDX_W | Slot the result belongs to |
| wb_value | input | DATA_W | Result, or correct target for a branch |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispredict | input | 1 | Branch was mispredicted |
| lk_reg | input | REG_W | Register being looked up |
| lk_hit | output | 1 | An in-flight producer exists |
| lk_ready | output | 1 | Its value is available |
| lk_tag | output | IDX_W | Tag of the youngest producer |
| lk_value | output | DATA_W | Its value when ready |
| cm_reg_we | output | 1 | Register write retires |
| cm_reg_idx | output | REG_W | Register written |
| cm_store_we | output | 1 | Store retires |
| cm_store_addr | output | DEST_W | Store address |
| cm_value | output | DATA_W | Retiring value |
| flush_out | output | 1 | Buffer emptied, redirect valid |
| redirect_pc | output | PC_W | Fetch restart address |
| fault_pc | output | PC_W | PC of the faulting instruction |

## Verification
The bench targets younger results that complete before the oldest one. A design that retired out of order would emit register writes for them early, in the wrong order.

It checks that a writeback and a lookup of the same slot in one cycle return the new value. A design without this forwarding path would report the slot as not ready.

It fills the buffer so the tags wrap, then pushes one more request. A full-detection error would overwrite the oldest slot or create a phantom producer.

Finally it places a mispredicted branch and an excepting instruction at the oldest position, each with a complete younger slot behind it. A wrong flush would commit the younger result, pick the wrong redirect, or accept issue during the flush.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        K_REG    = 2'd0,
        K_STORE  = 2'd1,
        K_BRANCH = 2'd2
    } rob_kind_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rob_state_e;
endpackage

// File: rtl/rob_flush_fsm.sv
module rob_flush_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_at_head,
    output logic in_flush
);
    import rob_pkg::*;

    rob_state_e st_q, st_d;

    // next state: FAULT_SEEN and RESUME transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (fault_at_head) st_d = ST_FLUSH;
            ST_FLUSH: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_RUN:   in_flush = 1'b0;
            ST_FLUSH: in_flush = 1'b1;
        endcase
    end

    assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FLUSH) |=> (st_q == ST_RUN));
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int REG_W  = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  ent_valid,
    input  logic [DEPTH-1:0]  ent_ready,
    input  logic [DEPTH-1:0]  ent_is_reg,
    input  logic [REG_W-1:0]  ent_reg   [DEPTH],
    input  logic [DATA_W-1:0] ent_value [DEPTH],
    input  logic [IDX_W-1:0]  head,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic              lk_ready,
    output logic [IDX_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_value
);
    logic [IDX_W-1:0] idx;

    // walk oldest to youngest; the last match is the youngest producer
    always_comb begin
        lk_hit   = 1'b0;
        lk_ready = 1'b0;
        lk_tag   = '0;
        lk_value = '0;
        idx      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            idx = head + IDX_W'(i);
            if (ent_valid[idx] && ent_is_reg[idx] && ent_reg[idx] == lk_reg) begin
                lk_hit = 1'b1;
                lk_tag = idx;
                if (ent_ready[idx]) begin
                    lk_ready = 1'b1;
                    lk_value = ent_value[idx];
                end else if (wb_valid && wb_tag == idx) begin
                    lk_ready = 1'b1;
                    lk_value = wb_value;
                end else begin
                    lk_ready = 1'b0;
                    lk_value = '0;
                end
            end
        end
    end
endmodule

// File: rtl/rob_inorder.sv
module rob_inorder #(
    parameter int              DEPTH      = 8,   // power of two
    parameter int              DATA_W     = 16,
    parameter int              DEST_W     = 8,
    parameter int              REG_W      = 5,
    parameter int              PC_W       = 16,
    parameter logic [PC_W-1:0] HANDLER_PC = 16'h0F00,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_tag,
    output logic              full,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_exc,
    input  logic              wb_mispredict,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic              lk_ready,
    output logic [IDX_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_value,
    output logic              cm_reg_we,
    output logic [REG_W-1:0]  cm_reg_idx,
    output logic              cm_store_we,
    output logic [DEST_W-1:0] cm_store_addr,
    output logic [DATA_W-1:0] cm_value,
    output logic              flush_out,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [PC_W-1:0]   fault_pc
);
    import rob_pkg::*;

    logic [IDX_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  ent_valid, ent_ready, ent_exc, ent_mis, ent_is_reg;
    rob_kind_e         ent_kind  [DEPTH];
    logic [DEST_W-1:0] ent_dest  [DEPTH];
    logic [DATA_W-1:0] ent_value [DEPTH];
    logic [PC_W-1:0]   ent_pc    [DEPTH];
    logic [REG_W-1:0]  ent_reg   [DEPTH];
    logic [PC_W-1:0]   redir_q, fpc_q;
    logic              in_flush, head_done, flush_now, commit_go, alloc_go;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign ent_reg[g]    = ent_dest[g][REG_W-1:0];
        assign ent_is_reg[g] = (ent_kind[g] == K_REG);
    end

    assign head_done   = !in_flush && ent_valid[head_q] && ent_ready[head_q];
    assign flush_now   = head_done && (ent_exc[head_q] || ent_mis[head_q]);
    assign commit_go   = head_done && !ent_exc[head_q] && !ent_mis[head_q];
    assign full        = (cnt_q == CNT_W'(DEPTH));
    assign alloc_ready = !in_flush && !full && !flush_now;
    assign alloc_go    = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_q;

    rob_flush_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fault_at_head (flush_now),
        .in_flush      (in_flush)
    );

    // occupancy and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q    <= '0;
            tail_q    <= '0;
            cnt_q     <= '0;
            ent_valid <= '0;
            redir_q   <= '0;
            fpc_q     <= '0;
        end else if (flush_now) begin
            tail_q    <= head_q;
            cnt_q     <= '0;
            ent_valid <= '0;
            redir_q   <= ent_exc[head_q] ? HANDLER_PC : ent_value[head_q][PC_W-1:0];
            fpc_q     <= ent_pc[head_q];
        end else begin
            if (alloc_go) begin
                ent_valid[tail_q] <= 1'b1;
                tail_q            <= tail_q + IDX_W'(1);
            end
            if (commit_go) begin
                ent_valid[head_q] <= 1'b0;
                head_q            <= head_q + IDX_W'(1);
            end
            cnt_q <= cnt_q + CNT_W'(alloc_go) - CNT_W'(commit_go);
        end
    end

    // slot payload, qualified by ent_valid
    always_ff @(posedge clk) begin
        if (alloc_go) begin
            ent_kind[tail_q]  <= rob_kind_e'(alloc_kind);
            ent_dest[tail_q]  <= alloc_dest;
            ent_pc[tail_q]    <= alloc_pc;
            ent_ready[tail_q] <= 1'b0;
            ent_exc[tail_q]   <= 1'b0;
            ent_mis[tail_q]   <= 1'b0;
        end
        if (wb_valid && ent_valid[wb_tag]) begin
            ent_value[wb_tag] <= wb_value;
            ent_ready[wb_tag] <= 1'b1;
            ent_exc[wb_tag]   <= wb_exc;
            ent_mis[wb_tag]   <= wb_mispredict;
        end
    end

    rob_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_lookup (
        .ent_valid  (ent_valid),
        .ent_ready  (ent_ready),
        .ent_is_reg (ent_is_reg),
        .ent_reg    (ent_reg),
        .ent_value  (ent_value),
        .head       (head_q),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_value   (wb_value),
        .lk_reg     (lk_reg),
        .lk_hit     (lk_hit),
        .lk_ready   (lk_ready),
        .lk_tag     (lk_tag),
        .lk_value   (lk_value)
    );

    assign cm_reg_we     = commit_go && ent_kind[head_q] == K_REG;
    assign cm_store_we   = commit_go && ent_kind[head_q] == K_STORE;
    assign cm_reg_idx    = ent_reg[head_q];
    assign cm_store_addr = ent_dest[head_q];
    assign cm_value      = ent_value[head_q];
    assign flush_out     = in_flush;
    assign redirect_pc   = in_flush ? redir_q : '0;
    assign fault_pc      = in_flush ? fpc_q : '0;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    assert_head_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_go |=> head_q == $past(head_q) + IDX_W'(1));
    assert_one_commit_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cm_reg_we, cm_store_we}));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |-> (cnt_q == '0 && ent_valid == '0));
    assert_no_commit_in_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |-> !(cm_reg_we || cm_store_we));
    assert_alloc_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |-> !alloc_ready);
endmodule

// File: tb/rob_inorder_tb.sv
module rob_inorder_tb_top;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_kind = '0;
    logic [7:0]  alloc_dest = '0;
    logic [15:0] alloc_pc = '0;
    logic        alloc_ready, full;
    logic [2:0]  alloc_tag;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [15:0] wb_value = '0;
    logic        wb_exc = 1'b0, wb_mispredict = 1'b0;
    logic [4:0]  lk_reg = '0;
    logic        lk_hit, lk_ready;
    logic [2:0]  lk_tag;
    logic [15:0] lk_value;
    logic        cm_reg_we, cm_store_we, flush_out;
    logic [4:0]  cm_reg_idx;
    logic [7:0]  cm_store_addr;
    logic [15:0] cm_value, redirect_pc, fault_pc;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    rob_inorder dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_pc(alloc_pc), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .full(full),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
        .wb_mispredict(wb_mispredict), .lk_reg(lk_reg), .lk_hit(lk_hit),
        .lk_ready(lk_ready), .lk_tag(lk_tag), .lk_value(lk_value),
        .cm_reg_we(cm_reg_we), .cm_reg_idx(cm_reg_idx), .cm_store_we(cm_store_we),
        .cm_store_addr(cm_store_addr), .cm_value(cm_value), .flush_out(flush_out),
        .redirect_pc(redirect_pc), .fault_pc(fault_pc)
    );

    // wb_en | wb_tag | wb_val | reg | hit | rdy | tag | val
    localparam logic [45:0] VEC [7] = '{
        {1'b0, 3'd0, 16'h0000, 5'd3, 1'b1, 1'b0, 3'd2, 16'h0000},
        {1'b0, 3'd0, 16'h0000, 5'd5, 1'b1, 1'b0, 3'd1, 16'h0000},
        {1'b0, 3'd0, 16'h0000, 5'd7, 1'b0, 1'b0, 3'd0, 16'h0000},
        {1'b1, 3'd2, 16'h2222, 5'd3, 1'b1, 1'b1, 3'd2, 16'h2222},
        {1'b0, 3'd0, 16'h0000, 5'd3, 1'b1, 1'b1, 3'd2, 16'h2222},
        {1'b1, 3'd1, 16'h5555, 5'd3, 1'b1, 1'b1, 3'd2, 16'h2222},
        {1'b0, 3'd0, 16'h0000, 5'd5, 1'b1, 1'b1, 3'd1, 16'h5555}
    };

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        alloc_valid   = 1'b0;
        wb_valid      = 1'b0;
        wb_exc        = 1'b0;
        wb_mispredict = 1'b0;
    endtask

    task automatic do_alloc(input logic [1:0] k, input logic [7:0] d, input logic [15:0] pc,
                            input int exp_tag, input string rq);
        alloc_valid = 1'b1; alloc_kind = k; alloc_dest = d; alloc_pc = pc;
        #1;
        chk(rq, "alloc_ready", 32'(alloc_ready), 1);
        chk(rq, "alloc_tag", 32'(alloc_tag), 32'(exp_tag));
        cyc();
    endtask

    task automatic do_wb(input logic [2:0] t, input logic [15:0] v, input logic e,
                         input logic m);
        wb_valid = 1'b1; wb_tag = t; wb_value = v; wb_exc = e; wb_mispredict = m;
        #1;
        cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "alloc_ready", 32'(alloc_ready), 1);
        chk("R1", "full", 32'(full), 0);
        chk("R1", "alloc_tag", 32'(alloc_tag), 0);
        chk("R1", "commit", 32'({cm_reg_we, cm_store_we}), 0);
        chk("R1", "flush", 32'(flush_out), 0);
        chk("R1", "lk_hit", 32'(lk_hit), 0);
        cyc();

        // R2 sequential tags
        do_alloc(2'd0, 8'd3, 16'h0100, 0, "R2");
        do_alloc(2'd0, 8'd5, 16'h0104, 1, "R2");
        do_alloc(2'd0, 8'd3, 16'h0108, 2, "R2");

        // lookup vectors (R4 R5 R6), head still incomplete so nothing retires (R7)
        for (int i = 0; i < 7; i++) begin
            string rq;
            rq = (i == 3) ? "R6" : ((i >= 4) ? "R4" : "R5");
            wb_valid = VEC[i][45]; wb_tag = VEC[i][44:42]; wb_value = VEC[i][41:26];
            lk_reg = VEC[i][25:21];
            #1;
            chk(rq, "lk_hit", 32'(lk_hit), 32'(VEC[i][20]));
            if (VEC[i][20]) begin
                chk(rq, "lk_ready", 32'(lk_ready), 32'(VEC[i][19]));
                chk(rq, "lk_tag", 32'(lk_tag), 32'(VEC[i][18:16]));
                if (VEC[i][19]) chk(rq, "lk_value", 32'(lk_value), 32'(VEC[i][15:0]));
            end
            chk("R7", "no early commit", 32'(cm_reg_we), 0);
            cyc();
        end

        // R7 R8 in-order retirement once head completes
        do_wb(3'd0, 16'h1111, 1'b0, 1'b0);
        #1;
        chk("R7", "commit0 we", 32'(cm_reg_we), 1);
        chk("R8", "commit0 idx", 32'(cm_reg_idx), 3);
        chk("R8", "commit0 val", 32'(cm_value), 32'h1111);
        cyc(); #1;
        chk("R7", "commit1 idx", 32'(cm_reg_idx), 5);
        chk("R7", "commit1 val", 32'(cm_value), 32'h5555);
        cyc(); #1;
        chk("R7", "commit2 idx", 32'(cm_reg_idx), 3);
        chk("R7", "commit2 val", 32'(cm_value), 32'h2222);
        cyc(); lk_reg = 5'd3; #1;
        chk("R7", "idle we", 32'(cm_reg_we), 0);
        chk("R5", "r3 drained", 32'(lk_hit), 0);
        chk("R2", "tail", 32'(alloc_tag), 3);

        // R8 store retire; R5 store never matches a register lookup
        do_alloc(2'd1, 8'h80, 16'h010C, 3, "R8");
        lk_reg = 5'd0;
        wb_valid = 1'b1; wb_tag = 3'd3; wb_value = 16'hABCD;
        #1;
        chk("R5", "store no hit", 32'(lk_hit), 0);
        cyc(); #1;
        chk("R8", "store we", 32'(cm_store_we), 1);
        chk("R8", "store reg we", 32'(cm_reg_we), 0);
        chk("R8", "store addr", 32'(cm_store_addr), 32'h80);
        chk("R8", "store val", 32'(cm_value), 32'hABCD);
        cyc();

        // R2 R3 fill with wrap: branch then r1..r7
        do_alloc(2'd2, 8'd0, 16'h0200, 4, "R2");
        for (int i = 1; i < 8; i++)
            do_alloc(2'd0, 8'(i), 16'(16'h0200 + 4 * i), (4 + i) % 8, "R2");
        #1;
        chk("R3", "full", 32'(full), 1);
        chk("R3", "alloc_ready", 32'(alloc_ready), 0);
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 8'd9;
        #1;
        cyc();
        lk_reg = 5'd9; #1;
        chk("R3", "ignored alloc", 32'(lk_hit), 0);
        chk("R3", "still full", 32'(full), 1);
        lk_reg = 5'd7; #1;
        chk("R5", "wrap tag", 32'(lk_tag), 3);

        // R9 mispredict at head with a complete younger slot
        do_wb(3'd5, 16'h0101, 1'b0, 1'b0);
        do_wb(3'd4, 16'h0300, 1'b0, 1'b1);
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 8'd9;
        #1;
        chk("R11", "fault blocks alloc", 32'(alloc_ready), 0);
        chk("R9", "no commit", 32'({cm_reg_we, cm_store_we}), 0);
        chk("R9", "flush not yet", 32'(flush_out), 0);
        cyc(); #1;
        chk("R9", "flush", 32'(flush_out), 1);
        chk("R9", "redirect", 32'(redirect_pc), 32'h0300);
        chk("R9", "fault_pc", 32'(fault_pc), 32'h0200);
        chk("R9", "no younger commit", 32'(cm_reg_we), 0);
        chk("R11", "flush blocks alloc", 32'(alloc_ready), 0);
        cyc(); lk_reg = 5'd1; #1;
        chk("R9", "flush one cycle", 32'(flush_out), 0);
        chk("R9", "emptied", 32'(lk_hit), 0);
        chk("R9", "not full", 32'(full), 0);
        chk("R9", "tail at head", 32'(alloc_tag), 4);
        lk_reg = 5'd9; #1;
        chk("R11", "blocked alloc dropped", 32'(lk_hit), 0);

        // R8 correctly predicted branch retires silently
        do_alloc(2'd2, 8'd0, 16'h0300, 4, "R8");
        do_wb(3'd4, 16'h0304, 1'b0, 1'b0);
        #1;
        chk("R8", "branch no we", 32'({cm_reg_we, cm_store_we}), 0);
        chk("R8", "branch no flush", 32'(flush_out), 0);
        cyc(); #1;
        chk("R8", "branch still no flush", 32'(flush_out), 0);

        // R10 exception at head
        do_alloc(2'd0, 8'd2, 16'h0444, 5, "R10");
        do_alloc(2'd0, 8'd4, 16'h0448, 6, "R10");
        do_wb(3'd6, 16'h0066, 1'b0, 1'b0);
        chk("R10", "younger waits", 32'(cm_reg_we), 0);
        do_wb(3'd5, 16'h0055, 1'b1, 1'b0);
        #1;
        chk("R10", "no commit of faulting", 32'(cm_reg_we), 0);
        cyc(); #1;
        chk("R10", "flush", 32'(flush_out), 1);
        chk("R10", "handler", 32'(redirect_pc), 32'h0F00);
        chk("R10", "fault_pc", 32'(fault_pc), 32'h0444);
        chk("R10", "no commit", 32'(cm_reg_we), 0);
        cyc(); lk_reg = 5'd4; #1;
        chk("R10", "younger discarded", 32'(lk_hit), 0);
        chk("R10", "tail at head", 32'(alloc_tag), 5);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule